// File: doc/BRIEF.md
# Parallel EPROM Byte-Read Controller

This block sits between a host and one asynchronous 512K x 8 EPROM and reads single bytes from it. The host presents a 19-bit address together with a request strobe. The controller drives the memory's address lines, chip-enable and output-enable, and waits for the access delays by counting clock cycles. It then captures the byte from the data bus and returns it with a one-cycle valid strobe. While no read is running, both enables stay high and the memory rests in low-power standby.

Every analog delay of the memory is a nanosecond parameter. At elaboration each one is turned into a whole number of clock cycles by rounding up against the clock period. The address and chip-enable are applied first. Output-enable is delayed so that it is low for exactly its own access time before the sampling edge. After output-enable is released, a float guard keeps the shared data bus reserved until the memory has stopped driving it. A cycle-time guard keeps successive addresses apart.

A second request kind runs an identifier read. With the high-voltage identifier request raised, the controller reads the manufacturer byte and then the device byte. It returns both codes and flags an error when either code differs from its expected value.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During reset, and whenever no access is running, mem_ce_n and mem_oe_n are both 1, mem_id_hv is 0, and rd_valid and id_valid are 0. Once the float window has ended, bus_free and req_ready are 1.
- R2: The data byte is captured on the clock edge that lies SAMPLE = max(ceil(T_ACC/Tclk), ceil(T_CE/Tclk), ceil(T_OE/Tclk)) cycles after the accepting edge (12 cycles at the defaults). rd_valid is high for exactly the one cycle after that edge.
- R3: For a byte read, mem_addr equals the accepted req_addr. mem_ce_n falls on the accepting edge, and mem_addr does not change while mem_ce_n stays low.
- R4: mem_oe_n is low only while mem_ce_n is low. It goes low ceil(T_OE/Tclk) cycles before the sampling edge and rises on that edge.
- R5: After mem_oe_n rises, bus_free stays 0 for ceil(T_DF/Tclk) cycles (at least T_DF). No request is accepted before bus_free has returned to 1.
- R6: Two accepting edges are at least ceil(T_RC/Tclk) cycles apart.
- R7: A request raised while an access or a guard window is running sees req_ready low. The request is held off rather than lost: it is accepted once req_ready rises, and its own byte is returned.
- R8: A request with req_kind = 1 runs two accesses with mem_id_hv high throughout. The first uses an all-zero address (bit 0, the identifier select, low) and the second uses address 1. id_valid then pulses for one cycle, with id_mfr holding the first byte and id_dev the second.
- R9: id_err, valid with id_valid, is 1 exactly when id_mfr differs from 0xDA or id_dev differs from 0x86.
- R10: A byte read returns the data-bus byte unchanged on rd_data. mem_id_hv stays 0 during a byte read, and an identifier read never raises rd_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe; held until accepted |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_kind | input | 1 | 0 = byte read, 1 = identifier read |
| req_addr | input | 19 | Byte address for a byte read |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds a new byte |
| rd_data | output | 8 | Byte returned by the last byte read |
| id_valid | output | 1 | One-cycle strobe: identifier codes updated |
| id_mfr | output | 8 | Manufacturer code read |
| id_dev | output | 8 | Device code read |
| id_err | output | 1 | Identifier code mismatch |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_id_hv | output | 1 | Request to raise the identifier high voltage |
| mem_dq_in | input | 8 | Memory data bus, as seen by the controller |
| bus_free | output | 1 | Other drivers may use the shared data bus |

## Verification
The assertions assume that req_valid, once raised, stays high with req_addr and req_kind held until the request is accepted, and that mem_dq_in is only meaningful while both enables are low. They also assume that nothing other than this controller moves the memory's control lines. The bench drives every request through a single task that raises the strobe on a falling edge and holds the address and kind until req_ready has been seen. Its memory model drives the bus only while both enables are low, so the stimulus stays within these assumptions. The access, float and cycle-time windows are measured in nanoseconds from the actual pin transitions rather than from the design's cycle counts.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_ACCESS = 2'd1,
      SQ_IDGAP  = 2'd2
   } sq_state_e;

   // Whole cycles needed to cover a delay given in nanoseconds (rounded up).
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      return max2(max2(a, b), c);
   endfunction

endpackage

// File: rtl/eprom_rd_age.sv
// Saturating count of cycles since the last access started.
module eprom_rd_age #(
   parameter int unsigned AGE_MAX = 11,
   parameter int unsigned AGE_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [AGE_W-1:0] age
);

   localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age <= SAT;
      end else if (clear) begin
         age <= '0;
      end else if (age != SAT) begin
         age <= age + 1'b1;
      end
   end

endmodule

// File: rtl/eprom_rd_float.sv
// Holds the shared data bus reserved after output-enable is released.
module eprom_rd_float #(
   parameter int unsigned DF_C = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);

   generate
      if (DF_C == 0) begin : g_none
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, load};
         assign done = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DF_C + 1);
         localparam logic [CW-1:0] LOADV = CW'(DF_C);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= LOADV;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign done = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/eprom_rd_id.sv
// Captures the two identifier codes and compares them with the expected values.
module eprom_rd_id #(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h86,
   parameter bit                CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_mfr,
   input  logic              cap_dev,
   input  logic [DATA_W-1:0] code_in,
   output logic [DATA_W-1:0] id_mfr,
   output logic [DATA_W-1:0] id_dev,
   output logic              id_valid,
   output logic              id_err
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_mfr   <= '0;
         id_dev   <= '0;
         id_valid <= 1'b0;
      end else begin
         id_valid <= cap_dev;
         if (cap_mfr) id_mfr <= code_in;
         if (cap_dev) id_dev <= code_in;
      end
   end

   generate
      if (CHECK_EN) begin : g_check
         logic err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               err_q <= 1'b0;
            end else if (cap_dev) begin
               err_q <= (id_mfr != MFR_CODE) || (code_in != DEV_CODE);
            end
         end
         assign id_err = err_q;
      end else begin : g_nocheck
         assign id_err = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/eprom_rd_seq.sv
// Access sequencer: address and chip enable first, output enable deferred,
// sample at the end of the slowest access path, then guard windows.
module eprom_rd_seq
   import eprom_rd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned AGE_W     = 4,
   parameter int unsigned SAMPLE_AT = 11,
   parameter int unsigned LEAD_C    = 7,
   parameter int unsigned RC_AT     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   input  logic [AGE_W-1:0]  age,
   output logic              age_clear,
   input  logic              float_done,
   output logic              float_load,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_id_hv,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              id_cap_mfr,
   output logic              id_cap_dev
);

   sq_state_e         st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic              id_op_q;
   logic              half_q;
   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;

   logic rc_ok, oe_win, gap_ok, sample, start_new, start_id2;

   generate
      if (RC_AT == 0) begin : g_rc_free
         assign rc_ok = 1'b1;
      end else begin : g_rc_wait
         assign rc_ok = (age >= AGE_W'(RC_AT));
      end
      if (LEAD_C == 0) begin : g_oe_now
         assign oe_win = 1'b1;
      end else begin : g_oe_late
         assign oe_win = (age >= AGE_W'(LEAD_C));
      end
   endgenerate

   assign gap_ok     = float_done && rc_ok;
   assign req_ready  = (st_q == SQ_IDLE) && gap_ok;
   assign start_new  = req_ready && req_valid;
   assign start_id2  = (st_q == SQ_IDGAP) && gap_ok;
   assign sample     = (st_q == SQ_ACCESS) && (age == AGE_W'(SAMPLE_AT));
   assign age_clear  = start_new || start_id2;
   assign float_load = sample;

   assign mem_addr   = addr_q;
   assign mem_ce_n   = (st_q != SQ_ACCESS);
   assign mem_oe_n   = !((st_q == SQ_ACCESS) && oe_win);
   assign mem_id_hv  = id_op_q;
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign id_cap_mfr = sample && id_op_q && !half_q;
   assign id_cap_dev = sample && id_op_q && half_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE:   if (start_new) st_d = SQ_ACCESS;
         SQ_ACCESS: if (sample)    st_d = (id_op_q && !half_q) ? SQ_IDGAP : SQ_IDLE;
         SQ_IDGAP:  if (gap_ok)    st_d = SQ_ACCESS;
         default:                  st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         addr_q     <= '0;
         id_op_q    <= 1'b0;
         half_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         st_q       <= st_d;
         rd_valid_q <= sample && !id_op_q;
         if (start_new) begin
            addr_q  <= req_kind ? '0 : req_addr;
            id_op_q <= req_kind;
            half_q  <= 1'b0;
         end
         if (start_id2) begin
            addr_q <= ADDR_W'(1);
            half_q <= 1'b1;
         end
         if (sample && !id_op_q) rd_data_q <= dq_in;
         if (sample && id_op_q && half_q) id_op_q <= 1'b0;
      end
   end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
   import eprom_rd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 8,
   parameter int unsigned T_ACC_NS      = 90,
   parameter int unsigned T_CE_NS       = 90,
   parameter int unsigned T_OE_NS       = 40,
   parameter int unsigned T_DF_NS       = 30,
   parameter int unsigned T_RC_NS       = 90,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h86,
   parameter bit          CHECK_ID      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              id_valid,
   output logic [DATA_W-1:0] id_mfr,
   output logic [DATA_W-1:0] id_dev,
   output logic              id_err,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_id_hv,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              bus_free
);

   localparam int unsigned ACC_C     = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
   localparam int unsigned CE_C      = ns_to_cyc(T_CE_NS,  CLK_PERIOD_NS);
   localparam int unsigned OE_C      = ns_to_cyc(T_OE_NS,  CLK_PERIOD_NS);
   localparam int unsigned DF_C      = ns_to_cyc(T_DF_NS,  CLK_PERIOD_NS);
   localparam int unsigned RC_C      = ns_to_cyc(T_RC_NS,  CLK_PERIOD_NS);
   localparam int unsigned SAMPLE_C  = max3(ACC_C, CE_C, OE_C);
   localparam int unsigned LEAD_C    = SAMPLE_C - OE_C;
   localparam int unsigned SAMPLE_AT = SAMPLE_C - 1;
   localparam int unsigned RC_AT     = (RC_C > 0) ? RC_C - 1 : 0;
   localparam int unsigned AGE_MAX   = max2(SAMPLE_AT, RC_AT);
   localparam int unsigned AGE_W     = max2(1, $clog2(AGE_MAX + 1));

   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("eprom_rd_ctrl: CLK_PERIOD_NS must be non-zero");
      end
      if (T_ACC_NS == 0 || T_CE_NS == 0 || T_OE_NS == 0) begin : g_bad_access
         $error("eprom_rd_ctrl: access delays must be non-zero");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("eprom_rd_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic [AGE_W-1:0] age;
   logic             age_clear;
   logic             float_load;
   logic             float_done;
   logic             id_cap_mfr;
   logic             id_cap_dev;

   eprom_rd_age #(
      .AGE_MAX (AGE_MAX),
      .AGE_W   (AGE_W)
   ) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (age_clear),
      .age   (age)
   );

   eprom_rd_float #(
      .DF_C (DF_C)
   ) u_float (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (float_load),
      .done  (float_done)
   );

   eprom_rd_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .AGE_W     (AGE_W),
      .SAMPLE_AT (SAMPLE_AT),
      .LEAD_C    (LEAD_C),
      .RC_AT     (RC_AT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_addr   (req_addr),
      .req_ready  (req_ready),
      .age        (age),
      .age_clear  (age_clear),
      .float_done (float_done),
      .float_load (float_load),
      .dq_in      (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_id_hv  (mem_id_hv),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .id_cap_mfr (id_cap_mfr),
      .id_cap_dev (id_cap_dev)
   );

   eprom_rd_id #(
      .DATA_W   (DATA_W),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE),
      .CHECK_EN (CHECK_ID)
   ) u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_mfr  (id_cap_mfr),
      .cap_dev  (id_cap_dev),
      .code_in  (mem_dq_in),
      .id_mfr   (id_mfr),
      .id_dev   (id_dev),
      .id_valid (id_valid),
      .id_err   (id_err)
   );

   assign bus_free = float_done && mem_oe_n;

   AST_CE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));                // R3
   AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n);                                             // R4
   AST_FLOAT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> !bus_free);                                       // R5
   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (mem_ce_n && bus_free));                 // R5
   AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_oe_n));                                       // R2
   AST_READ_NO_HV: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(mem_id_hv));                                      // R10
   AST_ID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> ($past(mem_id_hv) && $past(mem_addr[0])));               // R8

endmodule

// File: tb/eprom_rd_ctrl_bench.sv
module eprom_rd_ctrl_bench;

   localparam int PER      = 8;
   localparam int ACC_C    = (90 + PER - 1) / PER;
   localparam int OE_C     = (40 + PER - 1) / PER;
   localparam int DF_C     = (30 + PER - 1) / PER;
   localparam int RC_C     = (90 + PER - 1) / PER;
   localparam int SAMPLE_C = (ACC_C > OE_C) ? ACC_C : OE_C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_kind = 1'b0;
   logic [18:0] req_addr = '0;
   logic        req_ready, rd_valid, id_valid, id_err;
   logic [7:0]  rd_data, id_mfr, id_dev;
   logic [18:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_id_hv, bus_free;
   logic [7:0]  mem_dq_in;
   logic [7:0]  mfr_model = 8'hDA;
   logic [7:0]  dev_model = 8'h86;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   eprom_rd_ctrl u_eprom_rd_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .id_valid  (id_valid),
      .id_mfr    (id_mfr),
      .id_dev    (id_dev),
      .id_err    (id_err),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_id_hv (mem_id_hv),
      .mem_dq_in (mem_dq_in),
      .bus_free  (bus_free)
   );

   function automatic logic [7:0] pattern(input logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
   endfunction

   // Memory model: drives the bus only with both enables low.
   always_comb begin
      if (!mem_ce_n && !mem_oe_n)
         mem_dq_in = mem_id_hv ? (mem_addr[0] ? dev_model : mfr_model) : pattern(mem_addr);
      else
         mem_dq_in = 8'h00;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Pin-level timing monitors, measured in ns.
   time t_addr = 0, t_ce = 0, t_oe = 0, t_rel = 0;
   bit  oe_seen = 1'b0, rel_seen = 1'b0;

   always @(mem_addr) t_addr = $time;
   always @(negedge mem_ce_n) t_ce = $time;
   always @(negedge mem_oe_n) if (rst_n) begin t_oe = $time; oe_seen = 1'b1; end
   always @(posedge mem_oe_n) begin
      if (rst_n && oe_seen) begin
         chk(($time - t_addr) >= 90, "R2 address access time", $time - t_addr, 90);
         chk(($time - t_ce) >= 90, "R2 chip-enable access time", $time - t_ce, 90);
         chk(($time - t_oe) >= 40, "R4 output-enable access time", $time - t_oe, 40);
         chk(($time - t_oe) <= 40 + PER - 1, "R4 output-enable window length", $time - t_oe, 40);
         t_rel = $time;
         rel_seen = 1'b1;
      end
   end
   always @(posedge bus_free) begin
      if (rst_n && rel_seen)
         chk(($time - t_rel) >= 30, "R5 float time", $time - t_rel, 30);
   end

   task automatic issue(input logic [18:0] a, input logic k, output int acc, output int waited);
      @(negedge clk);
      req_addr  = a;
      req_kind  = k;
      req_valid = 1'b1;
      waited    = 0;
      while (!req_ready && waited < 200) begin
         waited++;
         @(negedge clk);
      end
      acc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n, "R1 enables high in reset", {mem_ce_n, mem_oe_n}, 2'b11);
      chk(!mem_id_hv && !rd_valid && !id_valid, "R1 strobes low in reset",
          {mem_id_hv, rd_valid, id_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && bus_free, "R1 ready and bus free after reset", {req_ready, bus_free}, 2'b11);
      chk(mem_ce_n && mem_oe_n, "R1 standby after reset", {mem_ce_n, mem_oe_n}, 2'b11);
   endtask

   task automatic t_read(input logic [18:0] a, output int acc, output int waited);
      int lat = -1;
      bit a_ok = 1'b1;
      bit hv_ok = 1'b1;
      issue(a, 1'b0, acc, waited);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (!mem_ce_n && mem_addr !== a) a_ok = 1'b0;
         if (mem_id_hv) hv_ok = 1'b0;
         if (rd_valid) begin
            lat = cyc - acc;
            break;
         end
      end
      chk(lat == SAMPLE_C, "R2 read latency", lat, SAMPLE_C);
      chk(rd_data == pattern(a), "R10 read data", rd_data, pattern(a));
      chk(a_ok, "R3 address held during access", a_ok, 1);
      chk(hv_ok, "R10 identifier request low on byte read", hv_ok, 1);
      @(negedge clk);
      chk(!rd_valid, "R2 valid is one cycle", rd_valid, 0);
      chk(mem_ce_n && mem_oe_n, "R1 standby after read", {mem_ce_n, mem_oe_n}, 2'b11);
   endtask

   task automatic t_back_to_back(input logic [18:0] a1, input logic [18:0] a2);
      int acc1, acc2, w1, w2;
      t_read(a1, acc1, w1);
      t_read(a2, acc2, w2);
      chk(w2 > 0, "R7 held-off request saw ready low", w2, 1);
      chk((acc2 - acc1) >= RC_C, "R6 read cycle spacing", acc2 - acc1, RC_C);
      chk((acc2 - acc1) >= SAMPLE_C + DF_C + 1, "R5 no accept inside float window",
          acc2 - acc1, SAMPLE_C + DF_C + 1);
   endtask

   task automatic t_ident(input logic [7:0] m, input logic [7:0] d, input bit exp_err);
      int acc, w;
      int segs = 0;
      bit prev_ce = 1'b1;
      bit a0_first = 1'b1;
      bit a0_second = 1'b0;
      bit ok = 1'b1;
      bit rdv = 1'b0;
      bit seen = 1'b0;
      mfr_model = m;
      dev_model = d;
      issue(19'h5555, 1'b1, acc, w);
      for (int i = 0; i < 128; i++) begin
         if (i > 0) @(negedge clk);
         if (prev_ce && !mem_ce_n) begin
            segs++;
            if (segs == 1) a0_first = mem_addr[0];
            else a0_second = mem_addr[0];
         end
         if (!mem_ce_n && (mem_addr[18:1] != 0 || !mem_id_hv)) ok = 1'b0;
         if (rd_valid) rdv = 1'b1;
         prev_ce = mem_ce_n;
         if (id_valid) begin
            seen = 1'b1;
            break;
         end
      end
      chk(seen, "R8 identifier read completes", seen, 1);
      chk(segs == 2, "R8 two accesses", segs, 2);
      chk(!a0_first && a0_second, "R8 select bit order", {a0_first, a0_second}, 2'b01);
      chk(ok, "R8 request high and upper address zero", ok, 1);
      chk(id_mfr == m, "R8 manufacturer code", id_mfr, m);
      chk(id_dev == d, "R8 device code", id_dev, d);
      chk(id_err == exp_err, "R9 code mismatch flag", id_err, exp_err);
      chk(!rdv, "R10 no byte strobe on identifier read", rdv, 0);
      @(negedge clk);
      chk(!id_valid && !mem_id_hv, "R8 strobe and request drop", {id_valid, mem_id_hv}, 0);
      mfr_model = 8'hDA;
      dev_model = 8'h86;
   endtask

   initial begin
      #(200000 * PER);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int acc, w;
      t_reset();
      t_read(19'h00000, acc, w);
      t_read(19'h7FFFF, acc, w);
      t_read(19'h2AAAA, acc, w);
      t_back_to_back(19'h15555, 19'h40001);
      t_ident(8'hDA, 8'h86, 1'b0);
      t_ident(8'hDA, 8'h87, 1'b1);
      t_ident(8'h5A, 8'h86, 1'b1);
      t_read(19'h12345, acc, w);
      repeat (8) @(negedge clk);
      chk(req_ready && bus_free && mem_ce_n, "R1 idle at end", {req_ready, bus_free, mem_ce_n}, 3'b111);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule